// File: doc/BRIEF.md
# Lane-Parallel Conditional Compute-Select Unit

This block evaluates one conditional expression across eight signed lanes at once, with no lane ever taking a different path from its neighbours. Every lane compares its own pair of operands, works out both candidate results, and keeps the one its comparison picks. The comparison bits are also exported as a lane mask, so logic downstream can see which arm each lane chose.

The unit sits on a valid/ready stream. A packed vector of operands is accepted whenever `in_valid` and `in_ready` are both high. The first stage registers the mask and both arm values. The second stage registers the selected results. Back-pressure from `out_ready` travels up through both stages. A stalled vector is held in place, and no vector is dropped or sent twice.

Top module: `csel_unit`

## Requirements
- R1: Bit i of `out_mask` is 1 exactly when the signed 16-bit operand a of lane i is strictly greater than the signed operand b of that lane. Equal operands give 0. Lane 0 maps to bit 0.
- R2: A lane whose mask bit is 1 outputs 3a+2b as a 20-bit two's complement value in `out_res[20*i+19:20*i]`.
- R3: A lane whose mask bit is 0 outputs a-4b as a 20-bit two's complement value in the same field.
- R4: Results are exact over the full operand range. This includes -32768 and 32767 used in either operand of either arm.
- R5: A vector accepted in cycle c appears with `out_valid` high in cycle c+2 when `out_ready` is high. `out_valid` is low in cycle c+1 if the pipeline was empty.
- R6: While `out_valid` is high and `out_ready` is low, the next cycle still shows `out_valid` high, with `out_res` and `out_mask` unchanged.
- R7: Accepted vectors leave in acceptance order, each exactly once. The unit never holds more than two vectors.
- R8: While reset is asserted, and right after it is released, `out_valid` is low. `in_ready` is low while reset is asserted and high once the unit is out of reset and empty.
- R9: A lane's result and mask bit depend only on that lane's operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| in_valid | input | 1 | Operand vector present |
| in_ready | output | 1 | Unit can take an operand vector this cycle |
| in_a | input | 128 | Eight signed 16-bit a operands, lane i at bits [16i+15:16i] |
| in_b | input | 128 | Eight signed 16-bit b operands, same packing |
| out_valid | output | 1 | Result vector present |
| out_ready | input | 1 | Consumer takes the result vector this cycle |
| out_res | output | 160 | Eight signed 20-bit results, lane i at bits [20i+19:20i] |
| out_mask | output | 8 | Per-lane comparison result, lane 0 in bit 0 |

## Verification
The assertions assume that `in_a` and `in_b` carry known values whenever `in_valid` is high. They also assume that `out_ready` is always driven to a known level. They rely on nothing being accepted while the internal synchronized reset is still low, and the gated `in_ready` enforces this. The bench holds `in_valid` low through reset and until the reset check has passed. After that it presents only fully defined operand vectors, drawn from a grid of edge values, from extreme pairs and from seeded pseudo-random values, under steady, periodic and irregular `out_ready` patterns.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int CSEL_LANES = 8;
  localparam int CSEL_OPW   = 16;
  // 3a+2b and a-4b grow by at most 5x the operand magnitude: four guard bits suffice
  localparam int CSEL_GUARD = 4;

  function automatic int res_width(input int opw);
    return opw + CSEL_GUARD;
  endfunction
endpackage

// File: rtl/csel_rst_sync.sv
module csel_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sh_q;
  logic [1:0] sh_d;

  always_comb sh_d = {sh_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[1];
endmodule

// File: rtl/csel_lane.sv
module csel_lane #(
  parameter int OPW  = 16,
  parameter int RESW = 20
) (
  input  logic signed [OPW-1:0]  op_a,
  input  logic signed [OPW-1:0]  op_b,
  output logic                   take_then,
  output logic signed [RESW-1:0] then_val,
  output logic signed [RESW-1:0] else_val
);
  logic signed [RESW-1:0] ax;
  logic signed [RESW-1:0] bx;

  always_comb begin
    ax        = RESW'(op_a);
    bx        = RESW'(op_b);
    take_then = (op_a > op_b);
    // both arms are always evaluated; multiplies built from shifts and adds
    then_val  = (ax <<< 1) + ax + (bx <<< 1);
    else_val  = ax - (bx <<< 2);
  end
endmodule

// File: rtl/csel_stage.sv
module csel_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         d_valid,
  input  logic [W-1:0] d_data,
  output logic         q_valid,
  output logic [W-1:0] q_data
);
  logic         v_q, v_d;
  logic [W-1:0] dat_q, dat_d;

  always_comb begin
    v_d   = v_q;
    dat_d = dat_q;
    if (en) begin
      v_d = d_valid;
      if (d_valid) dat_d = d_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) dat_q <= dat_d;

  assign q_valid = v_q;
  assign q_data  = dat_q;
endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
#(
  parameter int LANES = CSEL_LANES,
  parameter int OPW   = CSEL_OPW,
  parameter int RESW  = res_width(CSEL_OPW)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*OPW-1:0]    in_a,
  input  logic [LANES*OPW-1:0]    in_b,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*RESW-1:0]   out_res,
  output logic [LANES-1:0]        out_mask
);
  localparam int RW  = LANES * RESW;
  localparam int S1W = LANES + 2 * RW;
  localparam int S2W = LANES + RW;

  logic             rst_s_n;
  logic [LANES-1:0] lane_gt;
  logic [RW-1:0]    then_all, else_all;
  logic [S1W-1:0]   s1_d, s1_q;
  logic             s1_v, s1_en, s1_load;
  logic [LANES-1:0] s1_mask;
  logic [RW-1:0]    s1_then, s1_else, sel_res;
  logic [S2W-1:0]   s2_d, s2_q;
  logic             s2_v, s2_en;

  csel_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_s_n));

  // stage 1 inputs: compare and both arms in every lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    csel_lane #(.OPW(OPW), .RESW(RESW)) u_lane (
      .op_a     (in_a[g*OPW +: OPW]),
      .op_b     (in_b[g*OPW +: OPW]),
      .take_then(lane_gt[g]),
      .then_val (then_all[g*RESW +: RESW]),
      .else_val (else_all[g*RESW +: RESW])
    );
  end

  // back-pressure chain
  always_comb begin
    s2_en    = out_ready | ~s2_v;
    s1_en    = s2_en | ~s1_v;
    in_ready = s1_en & rst_s_n;
    s1_load  = in_valid & in_ready;
    s1_d     = {lane_gt, then_all, else_all};
  end

  csel_stage #(.W(S1W)) u_s1 (
    .clk(clk), .rst_n(rst_s_n), .en(s1_en), .d_valid(s1_load),
    .d_data(s1_d), .q_valid(s1_v), .q_data(s1_q)
  );

  always_comb begin
    s1_mask = s1_q[S1W-1 -: LANES];
    s1_then = s1_q[2*RW-1 : RW];
    s1_else = s1_q[RW-1 : 0];
  end

  // stage 2 inputs: per-lane select by mask bit
  for (genvar g = 0; g < LANES; g++) begin : g_sel
    always_comb
      sel_res[g*RESW +: RESW] = s1_mask[g] ? s1_then[g*RESW +: RESW]
                                           : s1_else[g*RESW +: RESW];
  end

  always_comb s2_d = {s1_mask, sel_res};

  csel_stage #(.W(S2W)) u_s2 (
    .clk(clk), .rst_n(rst_s_n), .en(s2_en), .d_valid(s1_v),
    .d_data(s2_d), .q_valid(s2_v), .q_data(s2_q)
  );

  assign out_valid = s2_v;
  assign out_mask  = s2_q[S2W-1 -: LANES];
  assign out_res   = s2_q[RW-1 : 0];
endmodule

// File: rtl/csel_unit_chk.sv
module csel_unit_chk #(
  parameter int LANES = 8,
  parameter int OPW   = 16,
  parameter int RESW  = 20
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [LANES*OPW-1:0]  in_a,
  input logic [LANES*OPW-1:0]  in_b,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [LANES*RESW-1:0] out_res,
  input logic [LANES-1:0]      out_mask
);
  function automatic logic [LANES-1:0] ref_mask(input logic [LANES*OPW-1:0] va,
                                                 input logic [LANES*OPW-1:0] vb);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++)
      m[i] = $signed(va[i*OPW +: OPW]) > $signed(vb[i*OPW +: OPW]);
    return m;
  endfunction

  function automatic logic [LANES*RESW-1:0] ref_res(input logic [LANES*OPW-1:0] va,
                                                    input logic [LANES*OPW-1:0] vb);
    logic [LANES*RESW-1:0] r;
    logic signed [31:0] ai, bi;
    for (int i = 0; i < LANES; i++) begin
      ai = 32'($signed(va[i*OPW +: OPW]));
      bi = 32'($signed(vb[i*OPW +: OPW]));
      r[i*RESW +: RESW] = (ai > bi) ? RESW'(3*ai + 2*bi) : RESW'(ai - 4*bi);
    end
    return r;
  endfunction

  logic [2:0] occ_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= 3'd0;
    else occ_q <= occ_q + 3'(in_valid && in_ready) - 3'(out_valid && out_ready);
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_mask)));

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 out_valid);

  assert_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 out_ready |=>
      (out_valid && out_mask == ref_mask($past(in_a, 2), $past(in_b, 2))));

  assert_select_R2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 out_ready |=>
      (out_res == ref_res($past(in_a, 2), $past(in_b, 2))));

  assert_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= 3'd2);

  assert_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == 3'd0) |-> !out_valid);
endmodule

bind csel_unit csel_unit_chk #(.LANES(LANES), .OPW(OPW), .RESW(RESW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_res(out_res), .out_mask(out_mask)
);

// File: tb/tb_csel_unit.sv
`timescale 1ns/1ps
module tb_csel_unit;
  localparam int LANES = 8;
  localparam int OPW   = 16;
  localparam int RESW  = 20;
  localparam int AW    = LANES * OPW;
  localparam int RW    = LANES * RESW;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [AW-1:0] in_a, in_b;
  logic [RW-1:0] out_res;
  logic [LANES-1:0] out_mask;

  always #4 clk = ~clk;

  csel_unit #(.LANES(LANES), .OPW(OPW), .RESW(RESW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_mask(out_mask)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int mode   = 0;
  bit finished = 0;
  string tag = "R2";
  logic took;
  logic stall_prev = 1'b0;
  logic [RW-1:0] hold_res;
  logic [LANES-1:0] hold_mask;
  logic [LANES-1:0] qm[$];
  logic [RW-1:0]    qr[$];

  function automatic logic [LANES-1:0] exp_mask(input logic [AW-1:0] va, input logic [AW-1:0] vb);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++)
      m[i] = int'($signed(va[i*OPW +: OPW])) > int'($signed(vb[i*OPW +: OPW]));
    return m;
  endfunction

  function automatic logic [RW-1:0] exp_res(input logic [AW-1:0] va, input logic [AW-1:0] vb);
    logic [RW-1:0] r;
    int ai, bi, th, el;
    for (int i = 0; i < LANES; i++) begin
      ai = int'($signed(va[i*OPW +: OPW]));
      bi = int'($signed(vb[i*OPW +: OPW]));
      th = 3 * ai + 2 * bi;
      el = ai - 4 * bi;
      r[i*RESW +: RESW] = (ai > bi) ? th[RESW-1:0] : el[RESW-1:0];
    end
    return r;
  endfunction

  function automatic logic rdy_now();
    if (mode == 0) return 1'b1;
    if (mode == 1) return (cyc % 3) != 0;
    return ($urandom % 4) != 0;
  endfunction

  task automatic observe();
    logic [LANES-1:0] em;
    logic [RW-1:0] er;
    if (stall_prev) begin
      checks++;
      if (!(out_valid && out_res == hold_res && out_mask == hold_mask)) begin
        fails++;
        $display("FAIL R6 hold: valid=%0b res=%h mask=%h expected valid=1 res=%h mask=%h",
                 out_valid, out_res, out_mask, hold_res, hold_mask);
      end
    end
    if (out_valid && out_ready) begin
      checks++;
      if (qm.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected output: got mask=%h expected no vector", out_mask);
      end else begin
        em = qm.pop_front();
        er = qr.pop_front();
        if (out_mask !== em) begin
          fails++;
          $display("FAIL R1 mask: got %b expected %b", out_mask, em);
        end
        for (int i = 0; i < LANES; i++) begin
          checks++;
          if (out_res[i*RESW +: RESW] !== er[i*RESW +: RESW]) begin
            fails++;
            $display("FAIL %s lane %0d: got %0d expected %0d",
                     (tag == "R2") ? (em[i] ? "R2" : "R3") : tag, i,
                     $signed(out_res[i*RESW +: RESW]), $signed(er[i*RESW +: RESW]));
          end
        end
      end
    end
    took = in_valid && in_ready;
    if (took) begin
      qm.push_back(exp_mask(in_a, in_b));
      qr.push_back(exp_res(in_a, in_b));
    end
    stall_prev = out_valid && !out_ready;
    hold_res   = out_res;
    hold_mask  = out_mask;
  endtask

  task automatic tick(input logic iv, input logic [AW-1:0] va, input logic [AW-1:0] vb);
    @(negedge clk);
    cyc++;
    in_valid  = iv;
    in_a      = va;
    in_b      = vb;
    out_ready = rdy_now();
    #1;
    observe();
  endtask

  task automatic send(input logic [AW-1:0] va, input logic [AW-1:0] vb);
    if (mode == 2 && ($urandom % 3) == 0) tick(1'b0, '0, '0);
    took = 1'b0;
    while (!took) tick(1'b1, va, vb);
  endtask

  task automatic drain();
    int saved = mode;
    mode = 0;
    for (int k = 0; k < 20 && qm.size() != 0; k++) tick(1'b0, '0, '0);
    tick(1'b0, '0, '0);
    mode = saved;
  endtask

  task automatic chk(input string req, input logic ok, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  initial begin
    automatic int grid[12] = '{-32768, -32767, -20000, -1000, -2, -1, 0, 1, 2, 999, 32766, 32767};
    logic [AW-1:0] va, vb;
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R8 during reset
    chk("R8 out_valid in reset", out_valid == 1'b0, int'(out_valid), 0);
    chk("R8 in_ready in reset", in_ready == 1'b0, int'(in_ready), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 out_valid after reset", out_valid == 1'b0, int'(out_valid), 0);
    chk("R8 in_ready after reset", in_ready == 1'b1, int'(in_ready), 1);

    // R5 latency on an empty pipeline
    mode = 0;
    for (int i = 0; i < LANES; i++) begin
      va[i*OPW +: OPW] = 16'(i * 7 - 20);
      vb[i*OPW +: OPW] = 16'(5 - i * 3);
    end
    tick(1'b1, va, vb);
    chk("R5 accepted", took == 1'b1, int'(took), 1);
    tick(1'b0, '0, '0);
    chk("R5 not early", out_valid == 1'b0, int'(out_valid), 0);
    tick(1'b0, '0, '0);
    chk("R5 valid at c+2", out_valid == 1'b1, int'(out_valid), 1);
    drain();

    // grid sweep of edge values, all pairs, under each ready pattern
    for (int m = 0; m < 3; m++) begin
      mode = m;
      for (int v = 0; v < 18; v++) begin
        for (int l = 0; l < LANES; l++) begin
          va[l*OPW +: OPW] = 16'(grid[(v*LANES + l) / 12]);
          vb[l*OPW +: OPW] = 16'(grid[(v*LANES + l) % 12]);
        end
        send(va, vb);
      end
      drain();
    end

    // R4 full-range extremes
    mode = 1;
    tag = "R4";
    va = {16'sd32767, -16'sd32768, 16'sd32767, -16'sd32768, 16'sd32767, -16'sd32768, 16'sd32766, 16'sd0};
    vb = {16'sd32766, 16'sd32767, -16'sd32768, -16'sd32768, 16'sd32767, -16'sd32767, 16'sd32767, -16'sd32768};
    send(va, vb);
    send(vb, va);
    drain();

    // R9 lanes independent: only lane 3 changes between two vectors
    tag = "R9";
    for (int i = 0; i < LANES; i++) begin
      va[i*OPW +: OPW] = 16'(100 * i - 300);
      vb[i*OPW +: OPW] = 16'(50 - 20 * i);
    end
    send(va, vb);
    va[3*OPW +: OPW] = 16'(-30000);
    send(va, vb);
    drain();

    // pseudo-random vectors with irregular ready and input gaps
    tag = "R2";
    mode = 2;
    for (int v = 0; v < 200; v++) begin
      for (int i = 0; i < LANES; i++) begin
        va[i*OPW +: OPW] = 16'($urandom);
        vb[i*OPW +: OPW] = 16'($urandom);
      end
      send(va, vb);
    end
    drain();

    chk("R7 all vectors delivered", qm.size() == 0, qm.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule